// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transceiver with Wake-on-Edge

This block is an asynchronous serial transceiver that carries 8-bit or 9-bit characters. On the transmit side a holding register sits in front of the shift register, so the host can queue the next character while the current one is still on the line. A shared tick generator runs at sixteen times the bit rate. Every transmit bit lasts sixteen ticks, and every hand-off from the holding register to the shift register happens only at the end of a bit period. When a character is waiting, it is moved into the shift register as the last data bit ends. The holding register is therefore free from the first cycle of the stop bit, and the next frame follows the stop bit with no gap.

The receiver synchronises the serial input and detects the falling edge of a start bit. It samples each bit in the middle of its sixteen ticks. A good frame is loaded into the receive register once, and the receive flag is set. A bad stop bit discards the frame. The host clears the flag with a read strobe.

A wake mode is provided for a sleeping host. While wake is armed, the receiver is held off and a falling edge on the input raises the receive flag. Reads do not clear the flag during this time. The wake enable clears itself on the next rising edge of the input, and after that a read clears the flag as usual.

Top module: `uart_autowake_top`

## Requirements
- R1: After reset, `txd`=1, `tx_buf_empty`=1, `tx_shift_empty`=1, `rx_if`=0, `rx_idle`=1, `wake_en`=0, `rx_data`=0.
- R2: A transmitted frame has these parts, in this order: a start bit of 0, the data bits LSB first, then a stop bit of 1. Each bit lasts 16*CLK_PER_TICK cycles. When `nine_en`=1, a ninth bit follows data bit 7. This ninth bit is the value last written through `tx9_we`/`tx9_d`, copied when the character enters the shift register.
- R3: Characters move into the shift register only at a bit-period boundary. A write made while the holding register is occupied, in a cycle with no hand-off, is ignored. Characters written back to back start exactly 10 (or 11) bit periods apart.
- R4: When a character is waiting, `tx_buf_empty` rises in the same cycle that the current frame's stop bit begins on `txd`.
- R5: A write in the same cycle that a stop bit ends, with nothing queued, produces exactly one frame of the written value. That frame starts one bit period later.
- R6: A write in the same cycle as a hand-off is accepted: the slot empties and refills at that edge, and `tx_buf_empty` stays 0.
- R7: `tx_shift_empty` is 1 exactly when no frame is being shifted. While it is 1, `txd` is 1.
- R8: A frame with a stop bit of 1 is loaded into `rx_data` once (8-bit data in bits [7:0] with bit 8 = 0, or the 9 bits when `nine_en`=1), and `rx_if` is set. `rx_if` falls only after `rx_rd` with wake off. If setting and clearing fall in the same cycle, setting wins.
- R9: A frame whose stop bit samples 0 is discarded: `rx_if` and `rx_data` are unchanged.
- R10: `rx_idle` is 0 from the detected start bit to the stop-bit sample, and 1 otherwise.
- R11: In 9-bit mode, writing the ninth transmit bit during a reception leaves the received data unchanged.
- R12: `wake_set` arms wake only while `rx_idle`=1. While `wake_en`=1, the receiver stays idle and loads nothing. A falling edge on `rxd` sets `rx_if`, and `rx_rd` does not clear `rx_if`.
- R13: `wake_en` clears itself on the first rising edge of `rxd` after the waking edge, and never sets without `wake_set`. After it clears, `rx_rd` clears `rx_if` and reception resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nine_en | input | 1 | 1 selects 9-bit characters |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Transmit character |
| tx9_we | input | 1 | Write strobe for the ninth transmit bit |
| tx9_d | input | 1 | Ninth transmit bit value |
| tx_buf_empty | output | 1 | Holding register free |
| tx_shift_empty | output | 1 | No frame being shifted |
| rx_rd | input | 1 | Receive read strobe |
| rx_data | output | 9 | Last received character |
| rx_if | output | 1 | Receive flag |
| rx_idle | output | 1 | No reception in progress |
| wake_set | input | 1 | Arms wake mode |
| wake_en | output | 1 | Wake mode armed |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
Two events can land on the same clock edge, and both are provoked deliberately. The first is a host write arriving at the edge where a bit period ends: either as the stop bit finishes with nothing queued, or at the hand-off of a waiting character. The bench learns the bit-boundary phase from an observed start bit and schedules `tx_wr` onto that exact edge. It then judges the result from the decoded line: how many frames appear, what they contain, and the cycle each one starts. The second is a receive completion meeting a read strobe. The bench holds `rx_rd` high through a whole frame and requires `rx_if` to be seen high for exactly one cycle, with the new data in place.

// File: rtl/uart_aw_pkg.sv
package uart_aw_pkg;
   localparam int OVS   = 16;
   localparam int OVS_W = $clog2(OVS);
   localparam int CHR_W = 9;

   typedef enum logic [1:0] {
      LN_IDLE  = 2'd0,
      LN_START = 2'd1,
      LN_DATA  = 2'd2,
      LN_STOP  = 2'd3
   } line_st_t;
endpackage

// File: rtl/uart_aw_tick.sv
module uart_aw_tick #(
   parameter int CLK_PER_TICK = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (CLK_PER_TICK < 1) begin : g_bad_div
      $error("CLK_PER_TICK must be at least 1");
   end

   if (CLK_PER_TICK == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(CLK_PER_TICK);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
   end
endmodule

// File: rtl/uart_aw_tx.sv
module uart_aw_tx
   import uart_aw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       nine_en,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       bit9_we,
   input  logic       bit9_d,
   output logic       txd,
   output logic       buf_empty,
   output logic       shift_empty
);
   localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

   logic [OVS_W-1:0] ovs_q;
   logic             bit_end;
   logic             hold_full_q;
   logic [7:0]       hold_q;
   logic             bit9_q;
   line_st_t         st_q;
   logic [CHR_W-1:0] sh_q;
   logic [3:0]       bcnt_q;
   logic             pend_q;
   logic             last_bit;
   logic             handoff;
   logic             accept;

   assign bit_end  = tick && (ovs_q == OVS_LAST);
   assign last_bit = (bcnt_q == (nine_en ? 4'd8 : 4'd7));
   assign handoff  = bit_end && hold_full_q &&
                     ((st_q == LN_IDLE) ||
                      ((st_q == LN_DATA) && last_bit) ||
                      ((st_q == LN_STOP) && !pend_q));
   assign accept   = wr && (!hold_full_q || handoff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovs_q <= '0;
      else if (tick) ovs_q <= ovs_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full_q <= 1'b0;
         hold_q      <= '0;
         bit9_q      <= 1'b0;
      end else begin
         if (accept) begin
            hold_q      <= wdata;
            hold_full_q <= 1'b1;
         end else if (handoff) begin
            hold_full_q <= 1'b0;
         end
         if (bit9_we) bit9_q <= bit9_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= LN_IDLE;
         sh_q   <= '0;
         bcnt_q <= '0;
         pend_q <= 1'b0;
      end else if (bit_end) begin
         case (st_q)
            LN_IDLE: begin
               if (handoff) begin
                  sh_q <= {bit9_q, hold_q};
                  st_q <= LN_START;
               end
            end
            LN_START: begin
               bcnt_q <= '0;
               st_q   <= LN_DATA;
            end
            LN_DATA: begin
               sh_q   <= sh_q >> 1;
               bcnt_q <= bcnt_q + 1'b1;
               if (last_bit) begin
                  st_q <= LN_STOP;
                  if (handoff) begin
                     sh_q   <= {bit9_q, hold_q};
                     pend_q <= 1'b1;
                  end
               end
            end
            default: begin
               if (pend_q) begin
                  pend_q <= 1'b0;
                  st_q   <= LN_START;
               end else if (handoff) begin
                  sh_q <= {bit9_q, hold_q};
                  st_q <= LN_START;
               end else begin
                  st_q <= LN_IDLE;
               end
            end
         endcase
      end
   end

   always_comb begin
      case (st_q)
         LN_START: txd = 1'b0;
         LN_DATA:  txd = sh_q[0];
         default:  txd = 1'b1;
      endcase
   end

   assign buf_empty   = !hold_full_q;
   assign shift_empty = (st_q == LN_IDLE);
endmodule

// File: rtl/uart_aw_rx.sv
module uart_aw_rx
   import uart_aw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             nine_en,
   input  logic             rxd_s,
   input  logic             hold_off,
   output logic             frame_ok,
   output logic [CHR_W-1:0] frame_data,
   output logic             idle
);
   localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
   localparam logic [OVS_W-1:0] OVS_MID  = OVS_W'(OVS / 2 - 1);

   line_st_t         st_q;
   logic [OVS_W-1:0] ovs_q;
   logic [3:0]       cnt_q;
   logic [CHR_W-1:0] sh_q;
   logic             prev_q;
   logic             fall;
   logic             last_bit;

   assign fall     = prev_q && !rxd_s;
   assign last_bit = (cnt_q == (nine_en ? 4'd8 : 4'd7));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= LN_IDLE;
         ovs_q      <= '0;
         cnt_q      <= '0;
         sh_q       <= '0;
         prev_q     <= 1'b1;
         frame_ok   <= 1'b0;
         frame_data <= '0;
      end else begin
         prev_q   <= rxd_s;
         frame_ok <= 1'b0;
         case (st_q)
            LN_IDLE: begin
               if (fall && !hold_off) begin
                  st_q  <= LN_START;
                  ovs_q <= '0;
               end
            end
            LN_START: begin
               if (tick) begin
                  if (ovs_q == OVS_MID) begin
                     ovs_q <= '0;
                     cnt_q <= '0;
                     st_q  <= rxd_s ? LN_IDLE : LN_DATA;
                  end else begin
                     ovs_q <= ovs_q + 1'b1;
                  end
               end
            end
            LN_DATA: begin
               if (tick) begin
                  ovs_q <= ovs_q + 1'b1;
                  if (ovs_q == OVS_LAST) begin
                     sh_q  <= {rxd_s, sh_q[CHR_W-1:1]};
                     cnt_q <= cnt_q + 1'b1;
                     if (last_bit) st_q <= LN_STOP;
                  end
               end
            end
            default: begin
               if (tick) begin
                  ovs_q <= ovs_q + 1'b1;
                  if (ovs_q == OVS_LAST) begin
                     st_q <= LN_IDLE;
                     if (rxd_s) begin
                        frame_ok   <= 1'b1;
                        frame_data <= nine_en ? sh_q : {1'b0, sh_q[CHR_W-1:1]};
                     end
                  end
               end
            end
         endcase
      end
   end

   assign idle = (st_q == LN_IDLE);
endmodule

// File: rtl/uart_autowake_top.sv
module uart_autowake_top
   import uart_aw_pkg::*;
#(
   parameter int CLK_PER_TICK = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nine_en,
   input  logic       tx_wr,
   input  logic [7:0] tx_data,
   input  logic       tx9_we,
   input  logic       tx9_d,
   output logic       tx_buf_empty,
   output logic       tx_shift_empty,
   input  logic       rx_rd,
   output logic [8:0] rx_data,
   output logic       rx_if,
   output logic       rx_idle,
   input  logic       wake_set,
   output logic       wake_en,
   input  logic       rxd,
   output logic       txd
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                   tick;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   wprev_q;
   logic                   woke_q;
   logic                   frame_ok;
   logic [CHR_W-1:0]       frame_data;
   logic                   wake_fall;

   uart_aw_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   uart_aw_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nine_en(nine_en),
      .wr(tx_wr), .wdata(tx_data), .bit9_we(tx9_we), .bit9_d(tx9_d),
      .txd(txd), .buf_empty(tx_buf_empty), .shift_empty(tx_shift_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
   end
   assign rx_s = sync_q[SYNC_STAGES-1];

   uart_aw_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nine_en(nine_en),
      .rxd_s(rx_s), .hold_off(wake_en), .frame_ok(frame_ok),
      .frame_data(frame_data), .idle(rx_idle)
   );

   assign wake_fall = wake_en && !woke_q && wprev_q && !rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wprev_q <= 1'b1;
         wake_en <= 1'b0;
         woke_q  <= 1'b0;
      end else begin
         wprev_q <= rx_s;
         if (!wake_en) begin
            if (wake_set && rx_idle) begin
               wake_en <= 1'b1;
               woke_q  <= 1'b0;
            end
         end else if (wake_fall) begin
            woke_q <= 1'b1;
         end else if (woke_q && !wprev_q && rx_s) begin
            wake_en <= 1'b0;
            woke_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_if   <= 1'b0;
         rx_data <= '0;
      end else begin
         if (frame_ok) rx_data <= frame_data;
         if (frame_ok || wake_fall)   rx_if <= 1'b1;
         else if (rx_rd && !wake_en)  rx_if <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_aw_chk.sv
module uart_aw_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_wr,
   input logic tx_buf_empty,
   input logic tx_shift_empty,
   input logic txd,
   input logic rx_rd,
   input logic rx_if,
   input logic rx_idle,
   input logic wake_set,
   input logic wake_en
);
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_shift_empty) |-> !txd);

   p_fill_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_buf_empty) |-> $past(tx_wr));

   p_line_high_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_shift_empty |-> txd);

   p_flag_clear_by_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_if) |-> ($past(rx_rd) && !$past(wake_en)));

   p_wake_keeps_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_en && rx_if) |=> rx_if);

   p_wake_holds_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wake_en |-> rx_idle);

   p_no_self_arm_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_en && !wake_set) |=> !wake_en);
endmodule

bind uart_autowake_top uart_aw_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_buf_empty(tx_buf_empty),
   .tx_shift_empty(tx_shift_empty), .txd(txd), .rx_rd(rx_rd), .rx_if(rx_if),
   .rx_idle(rx_idle), .wake_set(wake_set), .wake_en(wake_en)
);

// File: tb/tb_uart_autowake_top.sv
module tb_uart_autowake_top;
   localparam int DIV = 2;
   localparam int BIT = 16 * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nine_en = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx9_we = 1'b0;
   logic       tx9_d = 1'b0;
   logic       tx_buf_empty, tx_shift_empty;
   logic       rx_rd = 1'b0;
   logic [8:0] rx_data;
   logic       rx_if, rx_idle;
   logic       wake_set = 1'b0;
   logic       wake_en;
   logic       rxd = 1'b1;
   logic       txd;

   uart_autowake_top #(.CLK_PER_TICK(DIV), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .nine_en(nine_en), .tx_wr(tx_wr),
      .tx_data(tx_data), .tx9_we(tx9_we), .tx9_d(tx9_d),
      .tx_buf_empty(tx_buf_empty), .tx_shift_empty(tx_shift_empty),
      .rx_rd(rx_rd), .rx_data(rx_data), .rx_if(rx_if), .rx_idle(rx_idle),
      .wake_set(wake_set), .wake_en(wake_en), .rxd(rxd), .txd(txd)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // line monitor on txd
   bit         mon_nine = 1'b0;
   int         mon_n = 0;
   int         mon_stop_bad = 0;
   logic [8:0] mon_d [0:63];
   int         mon_c [0:63];

   initial begin
      logic prev;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && prev && (txd === 1'b0)) begin
            int s, nb;
            logic [8:0] d;
            s = cyc; nb = mon_nine ? 9 : 8; d = '0;
            for (int i = 1; i <= nb; i++) begin
               while (cyc < s + i * BIT + BIT / 2) @(negedge clk);
               d[i-1] = txd;
            end
            while (cyc < s + (nb + 1) * BIT + BIT / 2) @(negedge clk);
            if (txd !== 1'b1) mon_stop_bad++;
            if (mon_n < 64) begin
               mon_d[mon_n] = d;
               mon_c[mon_n] = s;
            end
            mon_n++;
         end
         prev = txd;
      end
   end

   task automatic wait_cyc(input int e);
      while (cyc < e) @(negedge clk);
   endtask

   task automatic wr_at(input int e, input logic [7:0] d);
      wait_cyc(e - 1);
      tx_wr = 1'b1; tx_data = d;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic wr_now(input logic [7:0] d);
      @(negedge clk);
      tx_wr = 1'b1; tx_data = d;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic wait_start(output int s);
      @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
      s = cyc;
   endtask

   task automatic wait_tx_quiet();
      @(negedge clk);
      while (!tx_shift_empty || !tx_buf_empty) @(negedge clk);
      repeat (BIT) @(negedge clk);
   endtask

   bit idle_mid;
   task automatic send_frame(input logic [8:0] d, input int nb, input bit stopv);
      @(negedge clk);
      rxd = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = d[i];
         repeat (BIT / 2) @(negedge clk);
         if (i == 0) idle_mid = rx_idle;
         repeat (BIT - BIT / 2) @(negedge clk);
      end
      rxd = stopv;
      repeat (BIT) @(negedge clk);
      rxd = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   task automatic rd_pulse();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int base, s, sa, bnd, hi;
      logic [7:0] v;
      logic [8:0] keep;
      bit sdone;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd", txd, 1);
      chk(tx_buf_empty == 1'b1, "R1 buf_empty", tx_buf_empty, 1);
      chk(tx_shift_empty == 1'b1, "R1 shift_empty", tx_shift_empty, 1);
      chk(rx_if == 1'b0, "R1 rx_if", rx_if, 0);
      chk(rx_idle == 1'b1, "R1 rx_idle", rx_idle, 1);
      chk(wake_en == 1'b0, "R1 wake_en", wake_en, 0);
      chk(rx_data == 9'h0, "R1 rx_data", rx_data, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R3: back-to-back sweep of 8-bit values
      base = mon_n;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         while (!tx_buf_empty) @(negedge clk);
         wr_now(8'(k * 17));
      end
      wait_tx_quiet();
      chk(mon_n == base + 16, "R2 frame count", mon_n, base + 16);
      chk(mon_stop_bad == 0, "R2 stop bits", mon_stop_bad, 0);
      for (int k = 0; k < 16; k++) begin
         chk(mon_d[base+k] == 9'(k * 17), "R2 data", mon_d[base+k], k * 17);
         if (k > 0)
            chk(mon_c[base+k] - mon_c[base+k-1] == 10 * BIT, "R3 spacing",
                mon_c[base+k] - mon_c[base+k-1], 10 * BIT);
      end
      chk(tx_shift_empty == 1'b1, "R7 empty after sweep", tx_shift_empty, 1);

      // R3: write while full and no hand-off is dropped
      base = mon_n;
      bnd = mon_c[base-1] + ((cyc + 4 - mon_c[base-1]) / BIT + 1) * BIT;
      wr_at(bnd + 2, 8'hC3);
      wr_at(bnd + 5, 8'h3C);
      wait_tx_quiet();
      chk(mon_n == base + 1, "R3 ignored write count", mon_n, base + 1);
      chk(mon_d[base] == 9'h0C3, "R3 kept data", mon_d[base], 9'h0C3);
      chk(mon_c[base] == bnd + BIT, "R3 boundary start", mon_c[base], bnd + BIT);

      // R4: buffer-empty rises with stop bit start
      base = mon_n;
      wr_now(8'h4B);
      wait_start(sa);
      wr_now(8'hB4);
      chk(tx_buf_empty == 1'b0, "R4 refilled", tx_buf_empty, 0);
      while (!tx_buf_empty) @(negedge clk);
      chk(cyc == sa + 9 * BIT, "R4 empty at stop start", cyc, sa + 9 * BIT);
      chk(txd == 1'b1, "R4 line in stop", txd, 1);
      wait_tx_quiet();
      chk(mon_n == base + 2, "R4 count", mon_n, base + 2);
      chk(mon_c[base+1] == sa + 10 * BIT, "R4 no gap", mon_c[base+1], sa + 10 * BIT);

      // R5: write on the stop-end edge
      base = mon_n;
      wr_now(8'h81);
      wait_start(s);
      wr_at(s + 10 * BIT, 8'h6E);
      chk(tx_shift_empty == 1'b1, "R7 idle after stop", tx_shift_empty, 1);
      chk(tx_buf_empty == 1'b0, "R5 held", tx_buf_empty, 0);
      wait_tx_quiet();
      chk(mon_n == base + 2, "R5 exactly one frame", mon_n, base + 2);
      chk(mon_d[base+1] == 9'h06E, "R5 data", mon_d[base+1], 9'h06E);
      chk(mon_c[base+1] == s + 11 * BIT, "R5 start", mon_c[base+1], s + 11 * BIT);

      // R6: write on the hand-off edge
      base = mon_n;
      wr_now(8'h11);
      wait_start(sa);
      wr_now(8'h22);
      wr_at(sa + 9 * BIT, 8'h33);
      chk(tx_buf_empty == 1'b0, "R6 slot refilled", tx_buf_empty, 0);
      wait_tx_quiet();
      chk(mon_n == base + 3, "R6 count", mon_n, base + 3);
      chk(mon_d[base+2] == 9'h033, "R6 third data", mon_d[base+2], 9'h033);
      chk(mon_c[base+2] == sa + 20 * BIT, "R6 third start", mon_c[base+2], sa + 20 * BIT);

      // R2: 9-bit transmit
      nine_en = 1'b1; mon_nine = 1'b1;
      base = mon_n;
      @(negedge clk); tx9_we = 1'b1; tx9_d = 1'b1;
      @(negedge clk); tx9_we = 1'b0;
      wr_now(8'hA5);
      wait_tx_quiet();
      @(negedge clk); tx9_we = 1'b1; tx9_d = 1'b0;
      @(negedge clk); tx9_we = 1'b0;
      wr_now(8'h5A);
      wait_tx_quiet();
      chk(mon_d[base] == 9'h1A5, "R2 ninth bit one", mon_d[base], 9'h1A5);
      chk(mon_d[base+1] == 9'h05A, "R2 ninth bit zero", mon_d[base+1], 9'h05A);
      nine_en = 1'b0; mon_nine = 1'b0;
      repeat (4) @(negedge clk);

      // R8 R10: receive sweep
      for (int k = 0; k < 16; k++) begin
         v = 8'(k * 17) ^ 8'h5C;
         send_frame({1'b0, v}, 8, 1'b1);
         chk(idle_mid == 1'b0, "R10 busy mid frame", idle_mid, 0);
         chk(rx_idle == 1'b1, "R10 idle after", rx_idle, 1);
         chk(rx_if == 1'b1, "R8 flag set", rx_if, 1);
         chk(rx_data == {1'b0, v}, "R8 data", rx_data, {1'b0, v});
         rd_pulse();
         chk(rx_if == 1'b0, "R8 read clears", rx_if, 0);
      end

      // R8: set beats clear in the same cycle
      rx_rd = 1'b1;
      sdone = 1'b0; hi = 0;
      fork
         begin send_frame(9'h0E7, 8, 1'b1); sdone = 1'b1; end
         begin while (!sdone) begin @(negedge clk); if (rx_if) hi++; end end
      join
      rx_rd = 1'b0;
      chk(hi == 1, "R8 set wins over read", hi, 1);
      chk(rx_data == 9'h0E7, "R8 data with read held", rx_data, 9'h0E7);

      // R9: bad stop bit discards the frame
      send_frame(9'h018, 8, 1'b0);
      chk(rx_if == 1'b0, "R9 no flag", rx_if, 0);
      chk(rx_data == 9'h0E7, "R9 data kept", rx_data, 9'h0E7);

      // R11: ninth tx bit written during 9-bit reception
      nine_en = 1'b1;
      sdone = 1'b0;
      fork
         begin send_frame(9'h1C3, 9, 1'b1); sdone = 1'b1; end
         begin
            while (!sdone) begin
               @(negedge clk); tx9_we = 1'b1; tx9_d = ~tx9_d;
               @(negedge clk); tx9_we = 1'b0;
            end
         end
      join
      chk(rx_data == 9'h1C3, "R11 nine-bit data", rx_data, 9'h1C3);
      rd_pulse();
      send_frame(9'h02A, 9, 1'b1);
      chk(rx_data == 9'h02A, "R11 nine-bit data low", rx_data, 9'h02A);
      rd_pulse();
      nine_en = 1'b0;

      // R12 R13: wake
      keep = rx_data;
      @(negedge clk); wake_set = 1'b1;
      @(negedge clk); wake_set = 1'b0;
      chk(wake_en == 1'b1, "R12 armed", wake_en, 1);
      chk(rx_if == 1'b0, "R12 flag clear before edge", rx_if, 0);
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      chk(rx_if == 1'b1, "R12 edge sets flag", rx_if, 1);
      rd_pulse();
      chk(rx_if == 1'b1, "R12 read does not clear", rx_if, 1);
      repeat (3 * BIT) @(negedge clk);
      chk(rx_idle == 1'b1, "R12 receiver held", rx_idle, 1);
      chk(wake_en == 1'b1, "R13 still armed while low", wake_en, 1);
      rxd = 1'b1;
      repeat (6) @(negedge clk);
      chk(wake_en == 1'b0, "R13 self clear", wake_en, 0);
      chk(rx_if == 1'b1, "R13 flag survives", rx_if, 1);
      chk(rx_data == keep, "R12 nothing loaded", rx_data, keep);
      rd_pulse();
      chk(rx_if == 1'b0, "R13 read clears after wake", rx_if, 0);
      send_frame(9'h096, 8, 1'b1);
      chk(rx_data == 9'h096, "R13 reception resumes", rx_data, 9'h096);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule